// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-side register front end of an audio codec. A host reaches it through four byte-wide direct addresses. One holds an index pointer. One is a data window into a bank of indirect control registers selected by that pointer. One is a status byte carrying the pending-interrupt flag. The last is a programmed-I/O data slot, which accepts nothing. The indirect bank holds 32 bytes. In the legacy mode only the lower 16 can be reached. A mode bit in indirect register 12 widens the pointer to five bits and opens the upper half.

The port applies per-register write rules. The playback format byte is protected by a mode-change-enable gate, with a partial path for the upper nibble only. A few registers are read-only or reserved. The mode register exposes a single bit to writes. The port models a short autocalibration window that shows as a busy bit on a limited number of reads. It keeps an interrupt flag that a playback engine raises and the host acknowledges. The format byte, the interface configuration byte and the mode bit are driven out continuously. A one-cycle strobe asks the playback path to reconfigure whenever the format byte is accepted.

Top module: `codec_regport`

## Requirements
- R1: After reset the index register reads 0x40. The indirect registers read: 2 to 5 at 0x88, 6 and 7 at 0x80, 9 at 0x08, 12 at 0x8A, 18 and 19 at 0x88, 25 and 26 at 0xA0, and all others 0x00. `irq` and `reconfig_stb` are low.
- R2: The index register (direct address 0) stores bits 6:0 of a write, and bit 7 always reads back as 0. Bit 6 is the mode-change-enable (MCE) bit.
- R3: The indirect register selected through direct address 1 is given by index bits 3:0 when bit 6 of indirect register 12 is 0, and by index bits 4:0 when that bit is 1.
- R4: A write to indirect register 8 with MCE set stores the whole byte. With MCE clear and bit 4 of indirect register 24 set, it stores only bits 7:4 and keeps the old bits 3:0. With both clear, the write is dropped. `reconfig_stb` is high for exactly the one cycle after an accepted write, and never otherwise. `fmt_cfg` always shows register 8.
- R5: Indirect register 9 always stores bit 5 as 0. Writes to registers 11, 22, 27 and 29 change nothing. A write to register 12 changes only its bit 6. Every other indirect register stores the written byte.
- R6: A write to the index register that takes MCE from 0 to 1, while bit 3 or bit 4 of indirect register 9 is set, loads a busy counter with CAL_READS. Each data read of indirect register 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R7: Any write to direct address 2 clears the interrupt flag (status bit 0), clears bits 6:4 of indirect register 24, and drops `irq`.
- R8: Writing indirect register 24 with bit 4 = 0 while its stored bit 4 is 1 clears the interrupt flag and drops `irq`. The written byte is stored.
- R9: A `play_done` pulse sets the interrupt flag and bit 4 of indirect register 24, and raises `irq` in the next cycle. When it coincides with a host clear, the set wins.
- R10: Writes to direct address 3 are ignored, and it reads 0x00. Direct address 2 reads as {7'b0, interrupt flag}.
- R11: Read data appears on `host_rdata` in the cycle after `host_rd` and holds until the next read. Reads change no state, except the R6 counter decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Direct address: 0 index, 1 data, 2 status, 3 PIO |
| host_wr | input | 1 | Write strobe, one byte |
| host_rd | input | 1 | Read strobe, one byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| play_done | input | 1 | Playback engine interrupt set |
| irq | output | 1 | Interrupt request |
| fmt_cfg | output | 8 | Indirect register 8 (rate and playback format) |
| iface_cfg | output | 8 | Indirect register 9 (interface configuration) |
| ext_mode | output | 1 | Extended indirect space enabled |
| reconfig_stb | output | 1 | Playback reconfiguration request |

## Verification
The main function is the write-then-read path through the index and data pair. It is swept over all 32 indirect slots with four byte patterns, each XORed with the slot number. The all-ones and all-zeros patterns expose stuck or masked bits. The alternating patterns separate neighbouring slots and catch aliasing. Legacy-mode aliasing is tried with an index above 15, to tell a 4-bit decode from a 5-bit one. The format byte is written under each of its three gate states, so a full write, a nibble merge and a dropped write can each be told apart. Interrupt flows pit the set input against each clear path alone and together, so a wrong priority shows up.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;
  localparam int DW   = 8;
  localparam int NREG = 32;
  localparam int AW   = $clog2(NREG);

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  localparam logic [AW-1:0] RI_FMT  = AW'(8);
  localparam logic [AW-1:0] RI_IFC  = AW'(9);
  localparam logic [AW-1:0] RI_CAL  = AW'(11);
  localparam logic [AW-1:0] RI_MODE = AW'(12);
  localparam logic [AW-1:0] RI_ALT  = AW'(24);
  localparam logic [AW-1:0] RI_RSVA = AW'(22);
  localparam logic [AW-1:0] RI_RSVB = AW'(27);
  localparam logic [AW-1:0] RI_RSVC = AW'(29);

  localparam int MCE_BIT  = 6;
  localparam int EXT_BIT  = 6;
  localparam int PEND_BIT = 4;
  localparam int BUSY_BIT = 5;

  function automatic logic [DW-1:0] reg_reset(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: reg_reset = 8'h88;
      6, 7:               reg_reset = 8'h80;
      9:                  reg_reset = 8'h08;
      12:                 reg_reset = 8'h8A;
      25, 26:             reg_reset = 8'hA0;
      default:            reg_reset = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cr_ibank.sv
module cr_ibank
  import codec_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          mce,
  input  logic          status_clr,
  input  logic          play_set,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] fmt,
  output logic [DW-1:0] ifc,
  output logic          ext,
  output logic          ack_clr,
  output logic          stb
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic          stb_d;

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    stb_d   = 1'b0;
    ack_clr = 1'b0;
    if (wr_en) begin
      case (waddr)
        RI_FMT: begin
          if (mce) begin
            regs_d[RI_FMT] = wdata;
            stb_d          = 1'b1;
          end else if (regs_q[RI_ALT][PEND_BIT]) begin
            regs_d[RI_FMT] = {wdata[7:4], regs_q[RI_FMT][3:0]};
            stb_d          = 1'b1;
          end
        end
        RI_IFC:  regs_d[RI_IFC] = wdata & 8'hDF;
        RI_CAL, RI_RSVA, RI_RSVB, RI_RSVC: ;
        RI_MODE: regs_d[RI_MODE][EXT_BIT] = wdata[EXT_BIT];
        RI_ALT: begin
          ack_clr        = regs_q[RI_ALT][PEND_BIT] & ~wdata[PEND_BIT];
          regs_d[RI_ALT] = wdata;
        end
        default: regs_d[waddr] = wdata;
      endcase
    end
    if (status_clr) regs_d[RI_ALT][6:4] = 3'b000;
    if (play_set)   regs_d[RI_ALT][PEND_BIT] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RV = reg_reset(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= RV;
      else        regs_q[g] <= regs_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= 1'b0;
    else        stb <= stb_d;
  end

  assign rd_data = regs_q[rd_addr];
  assign fmt     = regs_q[RI_FMT];
  assign ifc     = regs_q[RI_IFC];
  assign ext     = regs_q[RI_MODE][EXT_BIT];

  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(wr_en && waddr == RI_FMT)); // R4
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && waddr == RI_FMT) |=> $stable(fmt)); // R4
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    play_set |=> regs_q[RI_ALT][PEND_BIT]); // R9
endmodule

// File: rtl/cr_calib.sv
module cr_calib #(
  parameter int CAL_READS = 1,
  localparam int CW = $clog2(CAL_READS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic rd_hit,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = CW'(CAL_READS);
    else if (rd_hit && busy)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_CAL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_CAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rd_hit) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/cr_irq.sv
module cr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag); // R7
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set)); // R9
endmodule

// File: rtl/codec_regport.sv
module codec_regport
  import codec_regport_pkg::*;
#(
  parameter int CAL_READS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          play_done,
  output logic          irq,
  output logic [DW-1:0] fmt_cfg,
  output logic [DW-1:0] iface_cfg,
  output logic          ext_mode,
  output logic          reconfig_stb
);
  logic [DW-2:0] index_q, index_d;
  logic [DW-1:0] rdata_d;
  logic [AW-1:0] iaddr;
  logic [DW-1:0] bank_rd;
  logic          wr_idx, wr_dat, wr_sts;
  logic          cal_load, cal_hit, cal_busy, ack_clr, int_flag;

  assign wr_idx = host_wr && (host_addr == PORT_INDEX);
  assign wr_dat = host_wr && (host_addr == PORT_DATA);
  assign wr_sts = host_wr && (host_addr == PORT_STATUS);

  assign iaddr = ext_mode ? index_q[AW-1:0] : {1'b0, index_q[AW-2:0]};

  assign cal_load = wr_idx && !index_q[MCE_BIT] && host_wdata[MCE_BIT]
                    && (iface_cfg[3] || iface_cfg[4]);
  assign cal_hit  = host_rd && !host_wr && (host_addr == PORT_DATA) && (iaddr == RI_CAL);

  always_comb begin
    index_d = index_q;
    if (wr_idx) index_d = host_wdata[DW-2:0];
  end

  always_comb begin
    rdata_d = host_rdata;
    if (host_rd) begin
      case (host_addr)
        PORT_INDEX:  rdata_d = {1'b0, index_q};
        PORT_DATA:   rdata_d = bank_rd | ((iaddr == RI_CAL && cal_busy) ? DW'(1 << BUSY_BIT) : '0);
        PORT_STATUS: rdata_d = {{(DW-1){1'b0}}, int_flag};
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= 7'h40;
      host_rdata <= '0;
    end else begin
      index_q    <= index_d;
      host_rdata <= rdata_d;
    end
  end

  cr_ibank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_dat),
    .waddr      (iaddr),
    .wdata      (host_wdata),
    .mce        (index_q[MCE_BIT]),
    .status_clr (wr_sts),
    .play_set   (play_done),
    .rd_addr    (iaddr),
    .rd_data    (bank_rd),
    .fmt        (fmt_cfg),
    .ifc        (iface_cfg),
    .ext        (ext_mode),
    .ack_clr    (ack_clr),
    .stb        (reconfig_stb)
  );

  cr_calib #(.CAL_READS(CAL_READS)) u_cal (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cal_load),
    .rd_hit (cal_hit),
    .busy   (cal_busy)
  );

  cr_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (play_done),
    .clr   (wr_sts || ack_clr),
    .flag  (int_flag)
  );

  assign irq = int_flag;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata)); // R11
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !play_done) |=> !irq); // R7
  AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_idx |=> $stable(index_q)); // R2
endmodule

// File: tb/codec_regport_tb.sv
module codec_regport_tb;
  localparam int CAL_READS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_addr;
  logic       host_wr, host_rd, play_done;
  logic [7:0] host_wdata, host_rdata, fmt_cfg, iface_cfg;
  logic       irq, ext_mode, reconfig_stb;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_reg [32];
  logic [6:0] m_idx;
  logic       m_int;
  int         m_cal;

  always #4 clk = ~clk;

  codec_regport #(.CAL_READS(CAL_READS)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .play_done(play_done), .irq(irq), .fmt_cfg(fmt_cfg), .iface_cfg(iface_cfg),
    .ext_mode(ext_mode), .reconfig_stb(reconfig_stb)
  );

  function automatic logic [7:0] rst_of(input int n);
    if ((n >= 2 && n <= 5) || n == 18 || n == 19) return 8'h88;
    if (n == 6 || n == 7) return 8'h80;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    if (n == 25 || n == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] m_ia();
    return m_reg[12][6] ? m_idx[4:0] : {1'b0, m_idx[3:0]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [4:0] ia;
    logic stb;
    stb = 1'b0;
    case (a)
      2'd0: begin
        if (!m_idx[6] && d[6] && (m_reg[9][3] || m_reg[9][4])) m_cal = CAL_READS;
        m_idx = d[6:0];
      end
      2'd1: begin
        ia = m_ia();
        case (ia)
          5'd8: begin
            if (m_idx[6]) begin m_reg[8] = d; stb = 1'b1; end
            else if (m_reg[24][4]) begin m_reg[8] = {d[7:4], m_reg[8][3:0]}; stb = 1'b1; end
          end
          5'd9: m_reg[9] = d & 8'hDF;
          5'd11, 5'd22, 5'd27, 5'd29: ;
          5'd12: m_reg[12][6] = d[6];
          5'd24: begin
            if (m_reg[24][4] && !d[4]) m_int = 1'b0;
            m_reg[24] = d;
          end
          default: m_reg[ia] = d;
        endcase
      end
      2'd2: begin m_int = 1'b0; m_reg[24] = m_reg[24] & 8'h8F; end
      default: ;
    endcase
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #2;
    host_wr = 1'b0;
    chk("R4 strobe", {7'b0, reconfig_stb}, {7'b0, stb});
    chk("R7/R8 irq", {7'b0, irq}, {7'b0, m_int});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    logic [4:0] ia;
    case (a)
      2'd0: e = {1'b0, m_idx};
      2'd1: begin
        ia = m_ia();
        e = m_reg[ia];
        if (ia == 5'd11 && m_cal > 0) begin e = e | 8'h20; m_cal--; end
      end
      2'd2: e = {7'b0, m_int};
      default: e = 8'h00;
    endcase
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); #2;
    host_rd = 1'b0;
    chk(tag, host_rdata, e);
  endtask

  task automatic pulse_done(input logic with_clr);
    @(negedge clk);
    play_done = 1'b1;
    if (with_clr) begin
      host_addr = 2'd2; host_wr = 1'b1;
      m_reg[24] = m_reg[24] & 8'h8F;
    end
    m_int = 1'b1; m_reg[24][4] = 1'b1;
    @(posedge clk); #2;
    play_done = 1'b0; host_wr = 1'b0;
    chk("R9 irq set", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = 2'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; play_done = 1'b0;
    for (int i = 0; i < 32; i++) m_reg[i] = rst_of(i);
    m_idx = 7'h40; m_int = 1'b0; m_cal = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 stb", {7'b0, reconfig_stb}, 8'h00);
    rd(2'd0, "R1 index");
    for (int i = 0; i < 16; i++) begin wr(2'd0, 8'h40 | 8'(i)); rd(2'd1, "R1 low bank"); end
    wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
    chk("R3 ext_mode", {7'b0, ext_mode}, 8'h01);
    for (int i = 16; i < 32; i++) begin wr(2'd0, 8'h40 | 8'(i)); rd(2'd1, "R1 high bank"); end

    for (int p = 0; p < 4; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'hA5 : (p == 1) ? 8'h5A : (p == 2) ? 8'hFF : 8'h00;
      for (int i = 0; i < 32; i++) begin
        logic [7:0] d;
        d = pat ^ 8'(i);
        if (i == 12) d = d | 8'h40;
        wr(2'd0, 8'h40 | 8'(i));
        wr(2'd1, d);
      end
      for (int i = 0; i < 32; i++) begin wr(2'd0, 8'h40 | 8'(i)); rd(2'd1, "R5 sweep"); end
      chk("R4 fmt port", fmt_cfg, m_reg[8]);
    end

    wr(2'd0, 8'hFF); rd(2'd0, "R2 bit7 dropped");
    wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
    chk("R3 legacy", {7'b0, ext_mode}, 8'h00);
    wr(2'd0, 8'h53); wr(2'd1, 8'h3C); rd(2'd1, "R3 alias");
    wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
    wr(2'd0, 8'h53); rd(2'd1, "R3 reg19 untouched");
    wr(2'd0, 8'h43); rd(2'd1, "R3 reg3 got it");

    wr(2'd0, 8'h48); wr(2'd1, 8'h12);
    wr(2'd0, 8'h58); wr(2'd1, 8'h00);
    wr(2'd0, 8'h08); wr(2'd1, 8'hFF); rd(2'd1, "R4 dropped");
    wr(2'd0, 8'h18); wr(2'd1, 8'h10);
    wr(2'd0, 8'h08); wr(2'd1, 8'hE7); rd(2'd1, "R4 nibble");
    chk("R4 fmt port", fmt_cfg, 8'hE2);

    wr(2'd0, 8'h09); wr(2'd1, 8'h3F); rd(2'd1, "R5 bit5 zero");
    chk("R5 iface port", iface_cfg, 8'h1F);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd0, "R11 index read"); rd(2'd0, "R11 index read");
    rd(2'd1, "R6 busy 1"); rd(2'd1, "R6 busy 2"); rd(2'd1, "R6 expired");
    wr(2'd0, 8'h4B); rd(2'd1, "R6 no edge");
    wr(2'd0, 8'h09); wr(2'd1, 8'h00);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B); rd(2'd1, "R6 gated off");

    pulse_done(1'b0);
    rd(2'd2, "R10 status"); rd(2'd2, "R11 no side effect");
    wr(2'd0, 8'h58); rd(2'd1, "R9 pend bit");
    wr(2'd1, 8'h70); rd(2'd1, "R8 keep pend");
    wr(2'd2, 8'h00); rd(2'd1, "R7 bits cleared"); rd(2'd2, "R7 status");
    pulse_done(1'b0);
    wr(2'd1, 8'h00); rd(2'd2, "R8 ack");
    pulse_done(1'b1);
    rd(2'd2, "R9 priority"); rd(2'd1, "R9 priority reg24");
    wr(2'd3, 8'hAB); rd(2'd3, "R10 pio");
    chk("R10 irq kept", {7'b0, irq}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule